// File: doc/BRIEF.md
# Presettable Cascadable Binary Down Counter

This block is a parameterised binary down counter (8 bits by default) for frequency dividers and programmable timers. On each rising clock edge it either decrements, holds, or loads a parallel preset word. The preset word can also be forced into the count at once, without waiting for the clock. An active-low clear sets the count to all ones at once. When the counter decrements past zero it wraps to all ones, so a free-running stage divides by 2^WIDTH.

An active-low enable allows counting. An active-low terminal flag marks the zero count while that enable is asserted. Several stages can therefore be chained by feeding each stage's flag into the next stage's enable. All pins are plain control or status levels. The block has no streaming data path, so there is no valid/ready handshake and no back-pressure. The current count is exposed for observation.

Top module: `dnc_counter`

## Requirements
- R1: On a rising clock edge with en_n_i low, sload_n_i high and both asynchronous controls high, count_o becomes the previous count minus one, modulo 2^WIDTH.
- R2: On a rising clock edge with en_n_i high and sload_n_i high, count_o keeps its value. The value of jam_i has no effect in this case.
- R3: tc_n_o is low exactly when count_o is zero and en_n_i is low. It follows en_n_i combinationally, without waiting for a clock edge.
- R4: On a rising clock edge with sload_n_i low, count_o takes jam_i whatever the level of en_n_i. The preset word is unsigned, with bit 0 as its least significant bit.
- R5: A falling edge on aload_n_i loads jam_i into count_o immediately, between clock edges. While aload_n_i stays low, every rising clock edge reloads jam_i, overriding sload_n_i and en_n_i.
- R6: While clear_n_i is low, count_o is all ones, whatever the levels of aload_n_i and the other inputs.
- R7: With en_n_i low and no load, a zero count is followed by all ones, so a free-running stage repeats every 2^WIDTH clocks.
- R8: Two stages on one clock, with the low stage's tc_n_o driving the high stage's en_n_i, form a 2*WIDTH-bit counter. Its period is 2^(2*WIDTH) clocks. The high stage's tc_n_o is low for exactly one clock per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| clear_n_i | input | 1 | Asynchronous clear to all ones, active low, highest priority |
| aload_n_i | input | 1 | Asynchronous preset load, active low |
| sload_n_i | input | 1 | Synchronous preset load, active low, ignores en_n_i |
| en_n_i | input | 1 | Count enable, active low; also gates tc_n_o |
| jam_i | input | WIDTH | Preset word, bit 0 least significant |
| count_o | output | WIDTH | Current count |
| tc_n_o | output | 1 | Terminal flag, active low |

## Verification
The bench checks the edge that takes zero to all ones. A design that stops at zero, or goes back to the preset word, fails there. It loads with the enable deasserted, which catches a synchronous load wrongly gated by the enable. It asserts the asynchronous load in the middle of a cycle, so a load that waits for the clock reads the old count. It overlaps that load with the clear, so a wrong priority leaves the preset word instead of all ones. Toggling the enable mid-cycle at a zero count exposes a registered flag as a one-cycle lag. A full 65536-clock two-stage chain reveals any flag that lasts more or less than one clock, or a miscounted cascade.

// File: rtl/dnc_pkg.sv
package dnc_pkg;
  typedef enum logic [1:0] {
    DNC_HOLD = 2'd0,
    DNC_DEC  = 2'd1,
    DNC_LOAD = 2'd2
  } dnc_act_e;
endpackage

// File: rtl/dnc_ctl.sv
module dnc_ctl
  import dnc_pkg::*;
(
  input  logic     sload_n_i,
  input  logic     en_n_i,
  output dnc_act_e act_o
);
  // synchronous load outranks the enable; the enable alone picks decrement
  always_comb begin
    if (!sload_n_i)   act_o = DNC_LOAD;
    else if (!en_n_i) act_o = DNC_DEC;
    else              act_o = DNC_HOLD;
  end
endmodule

// File: rtl/dnc_dec.sv
module dnc_dec #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] cnt_i,
  output logic [WIDTH-1:0] dec_o,
  output logic             zero_o
);
  logic [WIDTH:0] borrow;
  assign borrow[0] = 1'b1;

  // ripple-borrow subtractor; the final borrow doubles as the zero detect
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign dec_o[b]    = cnt_i[b] ^ borrow[b];
    assign borrow[b+1] = borrow[b] & ~cnt_i[b];
  end

  assign zero_o = borrow[WIDTH];

  // R7
  always_comb zero_wrap_chk: assert (!zero_o || (dec_o == {WIDTH{1'b1}}));
endmodule

// File: rtl/dnc_reg.sv
module dnc_reg
  import dnc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             clear_n_i,
  input  logic             aload_n_i,
  input  dnc_act_e         act_i,
  input  logic [WIDTH-1:0] jam_i,
  input  logic [WIDTH-1:0] dec_i,
  output logic [WIDTH-1:0] cnt_o
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};

  always_ff @(posedge clk_i or negedge clear_n_i or negedge aload_n_i) begin
    if (!clear_n_i)      cnt_o <= ALL_ONES;
    else if (!aload_n_i) cnt_o <= jam_i;
    else begin
      unique case (act_i)
        DNC_LOAD: cnt_o <= jam_i;
        DNC_DEC:  cnt_o <= dec_i;
        default:  cnt_o <= cnt_o;
      endcase
    end
  end

  // R1
  dec_step_chk: assert property (@(posedge clk_i) disable iff (!clear_n_i || !aload_n_i)
    (act_i == DNC_DEC) |=> (cnt_o == $past(cnt_o) - ONE));

  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!clear_n_i || !aload_n_i)
    (act_i == DNC_HOLD) |=> $stable(cnt_o));

  // R4
  sync_load_chk: assert property (@(posedge clk_i) disable iff (!clear_n_i || !aload_n_i)
    (act_i == DNC_LOAD) |=> (cnt_o == $past(jam_i)));

  // R5
  async_load_chk: assert property (@(posedge clk_i) disable iff (!clear_n_i)
    !aload_n_i |-> (cnt_o == jam_i));

  // R6
  clear_val_chk: assert property (@(posedge clk_i) disable iff (1'b0)
    (!clear_n_i && $past(!clear_n_i)) |-> (cnt_o == ALL_ONES));
endmodule

// File: rtl/dnc_counter.sv
module dnc_counter
  import dnc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             clear_n_i,
  input  logic             aload_n_i,
  input  logic             sload_n_i,
  input  logic             en_n_i,
  input  logic [WIDTH-1:0] jam_i,
  output logic [WIDTH-1:0] count_o,
  output logic             tc_n_o
);
  dnc_act_e         act;
  logic [WIDTH-1:0] dec_val;
  logic             at_zero;

  dnc_ctl u_ctl (
    .sload_n_i (sload_n_i),
    .en_n_i    (en_n_i),
    .act_o     (act)
  );

  dnc_dec #(.WIDTH(WIDTH)) u_dec (
    .cnt_i  (count_o),
    .dec_o  (dec_val),
    .zero_o (at_zero)
  );

  dnc_reg #(.WIDTH(WIDTH)) u_reg (
    .clk_i     (clk_i),
    .clear_n_i (clear_n_i),
    .aload_n_i (aload_n_i),
    .act_i     (act),
    .jam_i     (jam_i),
    .dec_i     (dec_val),
    .cnt_o     (count_o)
  );

  // flag is gated by the enable so a chain advances one stage at a time
  assign tc_n_o = ~(at_zero & ~en_n_i);

  // R3
  tc_low_chk: assert property (@(posedge clk_i) disable iff (!clear_n_i)
    ((count_o == '0) && !en_n_i) |-> !tc_n_o);

  // R3
  tc_high_chk: assert property (@(posedge clk_i) disable iff (!clear_n_i)
    ((count_o != '0) || en_n_i) |-> tc_n_o);
endmodule

// File: tb/dnc_counter_tb.sv
module dnc_counter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int NVEC = 11;
  localparam int WATCHDOG = 150000;

  // vector: {sload_n, en_n, jam[7:0], exp_count[7:0], exp_tc_n}
  localparam logic [18:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 8'h03, 8'h03, 1'b1},  // R4 load with enable off
    {1'b1, 1'b0, 8'h00, 8'h02, 1'b1},  // R1
    {1'b1, 1'b0, 8'h00, 8'h01, 1'b1},  // R1
    {1'b1, 1'b0, 8'h00, 8'h00, 1'b0},  // R1 R3
    {1'b1, 1'b1, 8'hAA, 8'h00, 1'b1},  // R2 R3 gated flag
    {1'b1, 1'b0, 8'h00, 8'hFF, 1'b1},  // R7 wrap
    {1'b1, 1'b0, 8'h00, 8'hFE, 1'b1},  // R1
    {1'b0, 1'b0, 8'h80, 8'h80, 1'b1},  // R4
    {1'b0, 1'b1, 8'h00, 8'h00, 1'b1},  // R4 R3
    {1'b1, 1'b0, 8'h00, 8'hFF, 1'b1},  // R7
    {1'b1, 1'b1, 8'h55, 8'hFF, 1'b1}   // R2 jam ignored
  };

  logic         clk = 1'b0;
  logic         clear_n = 1'b0, aload_n = 1'b1, sload_n = 1'b1, en_n = 1'b1;
  logic [W-1:0] jam = '0;
  logic [W-1:0] count;
  logic         tc_n;

  logic         ch_clear_n = 1'b0;
  logic [W-1:0] lo_cnt, hi_cnt;
  logic         lo_tc_n, hi_tc_n;

  int tests = 0, fails = 0, cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dnc_counter #(.WIDTH(W)) dut_i (
    .clk_i(clk), .clear_n_i(clear_n), .aload_n_i(aload_n), .sload_n_i(sload_n),
    .en_n_i(en_n), .jam_i(jam), .count_o(count), .tc_n_o(tc_n)
  );

  dnc_counter #(.WIDTH(W)) chain_lo (
    .clk_i(clk), .clear_n_i(ch_clear_n), .aload_n_i(1'b1), .sload_n_i(1'b1),
    .en_n_i(1'b0), .jam_i('0), .count_o(lo_cnt), .tc_n_o(lo_tc_n)
  );

  dnc_counter #(.WIDTH(W)) chain_hi (
    .clk_i(clk), .clear_n_i(ch_clear_n), .aload_n_i(1'b1), .sload_n_i(1'b1),
    .en_n_i(lo_tc_n), .jam_i('0), .count_o(hi_cnt), .tc_n_o(hi_tc_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    // R6 reset state
    repeat (2) @(negedge clk);
    check("R6 reset count", count, 8'hFF);
    check("R3 reset flag", tc_n, 1'b1);
    clear_n = 1'b1;

    // vector table walk
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      sload_n = VEC[v][18];
      en_n    = VEC[v][17];
      jam     = VEC[v][16:9];
      @(posedge clk);
      #(CLK_PERIOD/4);
      check($sformatf("R1/R2/R4/R7 vec%0d count", v), count, VEC[v][8:1]);
      check($sformatf("R3 vec%0d flag", v), tc_n, VEC[v][0]);
    end

    // R3 flag follows enable between edges at zero count
    @(negedge clk);
    sload_n = 1'b0; en_n = 1'b1; jam = 8'h00;
    @(negedge clk);
    sload_n = 1'b1;
    check("R3 zero, enable off", tc_n, 1'b1);
    en_n = 1'b0;
    #1 check("R3 enable on mid-cycle", tc_n, 1'b0);
    en_n = 1'b1;
    #1 check("R3 enable off mid-cycle", tc_n, 1'b1);

    // R5 asynchronous load between edges
    @(negedge clk);
    en_n = 1'b0; jam = 8'h3C;
    #1 aload_n = 1'b0;
    #1 check("R5 load before edge", count, 8'h3C);
    @(negedge clk);
    check("R5 held across edge", count, 8'h3C);
    aload_n = 1'b1;
    @(negedge clk);
    check("R1 decrement after release", count, 8'h3B);

    // R6 clear outranks asynchronous load
    jam = 8'h11;
    clear_n = 1'b0;
    #1 aload_n = 1'b0;
    #1 check("R6 clear over load", count, 8'hFF);
    @(negedge clk);
    check("R6 still cleared", count, 8'hFF);
    aload_n = 1'b1;
    @(negedge clk);
    clear_n = 1'b1;
    en_n = 1'b1;
    @(negedge clk);
    check("R6 after release held", count, 8'hFF);

    // R8 two-stage chain, full period
    ch_clear_n = 1'b1;
    begin
      int bad = 0;
      int lows = 0;
      for (int k = 0; k <= 65536; k++) begin
        logic [15:0] exp_v;
        exp_v = 16'hFFFF - k[15:0];
        if ({hi_cnt, lo_cnt} !== exp_v) bad++;
        if ((hi_tc_n === 1'b0) != (exp_v == 16'h0000)) bad++;
        if (k < 65536 && hi_tc_n === 1'b0) lows++;
        @(negedge clk);
      end
      check("R8 chain sequence mismatches", bad, 0);
      check("R8 high flag pulses per period", lows, 1);
    end
    finish_run();
  end
endmodule